// File: doc/BRIEF.md
# Vector/Scalar Lane Transfer Unit

This block executes three kinds of instructions that move data between a 64-bit general register and a 128-bit vector register. A lane insert places the low bits of a general register into one element of a vector register and leaves the other elements as they were. A lane extract reads one element of a vector register into a general register, with sign or zero extension. A broadcast copies the low bits of a general register into every element of a vector register. Elements are 8, 16, 32 or 64 bits wide.

The surrounding pipeline supplies the 32-bit instruction word with a valid strobe. It also supplies the general-register value and the vector-register value read for that instruction. For insert, the vector value is the old contents of the destination register. For extract, it is the source register. The block decodes the word and one cycle later returns registered write enables, write addresses and write data for both register files. It also returns a flag for a malformed lane field and a flag for an instruction issued while the vector extension is turned off. Words that belong to none of the three kinds produce nothing.

Top module: `vgx_xfer`

## Requirements
- R1: During reset and in the first cycle after it, gpr_we, vreg_we, illegal and ext_disabled are all low, even with in_valid high during reset.
- R2: Insert is recognised by instr[31:15] = 17'b0111_00101110_10111. Bits 14:10 select the element size and the lane: 0iiii gives byte lane iiii, 10iii gives halfword, 110ii gives word and 1110i gives doubleword. Lane i of size S occupies bits i*S+S-1 down to i*S. vreg_wdata is vreg_rdata with that lane replaced and every other bit unchanged.
- R3: Insert writes only the low S bits of gpr_rdata into the lane. The upper general-register bits never reach the vector.
- R4: Signed extract is recognised by instr[31:15] = 17'b0111_00101110_11111. It uses the same bits 14:10 lane encoding as R2 and writes the selected lane, sign-extended to 64 bits, to gpr_wdata.
- R5: Unsigned extract is recognised by instr[31:15] = 17'b0111_00101111_00111. It writes the selected lane, zero-extended to 64 bits. For a doubleword lane, both extract forms return the lane unchanged.
- R6: Broadcast is recognised by instr[31:12] = 20'b0111_00101001_11110_000. instr[11:10] gives the size: 00 byte, 01 halfword, 10 word, 11 doubleword. vreg_wdata holds the low S bits of gpr_rdata in every lane.
- R7: Insert and broadcast assert vreg_we only, with vreg_waddr = instr[4:0]. Both extracts assert gpr_we only, with gpr_waddr = instr[4:0].
- R8: An insert or extract word whose bits 14:10 are 11110 or 11111 raises illegal and writes nothing.
- R9: With ext_en low, any of these words raises ext_disabled and writes nothing. ext_disabled takes priority over illegal, which stays low.
- R10: A valid word that matches none of these encodings raises no flag and writes nothing.
- R11: All outputs are registered and change one cycle after the input. Without in_valid, the next cycle has both write enables and both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word valid this cycle |
| instr | input | 32 | Instruction word |
| ext_en | input | 1 | Vector extension enabled |
| gpr_rdata | input | 64 | General register read value (source for insert/broadcast) |
| vreg_rdata | input | 128 | Vector register read value (old destination for insert, source for extract) |
| gpr_we | output | 1 | General register write enable |
| gpr_waddr | output | 5 | General register write index |
| gpr_wdata | output | 64 | General register write data |
| vreg_we | output | 1 | Vector register write enable |
| vreg_waddr | output | 5 | Vector register write index |
| vreg_wdata | output | 128 | Vector register write data |
| illegal | output | 1 | Malformed lane field |
| ext_disabled | output | 1 | Vector extension disabled exception |

## Verification
Insert is run at every element size, at the top lane and at lane 0, against a vector whose bytes all differ. A misplaced lane, an off-by-one shift or a disturbed neighbour therefore shows up as a wrong byte. Extract is tried on lanes with the top bit set and clear, in both signed and unsigned forms. This separates sign extension from zero extension and checks that the doubleword result is the same for both. Broadcast covers all four size codes with a general-register value whose bytes all differ, which exposes a wrong replication width. The flag cases pair malformed prefixes with enabled and disabled extension to show the priority, and near-miss opcodes to show that foreign words are left alone.

// File: rtl/vgx_pkg.sv
package vgx_pkg;

    localparam logic [16:0] OPC_INSERT = 17'b0111_00101110_10111;
    localparam logic [16:0] OPC_SEXT   = 17'b0111_00101110_11111;
    localparam logic [16:0] OPC_UEXT   = 17'b0111_00101111_00111;
    localparam logic [19:0] OPC_BCAST  = 20'b0111_00101001_11110_000;

    typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} esize_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_INSERT, OP_SEXT, OP_UEXT, OP_BCAST
    } xop_e;

    typedef struct packed {
        xop_e       op;
        esize_e     sz;
        logic [3:0] idx;
        logic       bad;
        logic [4:0] dst;
    } xdec_t;

endpackage

// File: rtl/vgx_decode.sv
module vgx_decode
    import vgx_pkg::*;
(
    input  logic [31:0] instr,
    output xdec_t       dec
);
    always_comb begin
        dec     = '0;
        dec.op  = OP_NONE;
        dec.sz  = SZ_B;
        dec.dst = instr[4:0];
        if (instr[31:15] == OPC_INSERT)      dec.op = OP_INSERT;
        else if (instr[31:15] == OPC_SEXT)   dec.op = OP_SEXT;
        else if (instr[31:15] == OPC_UEXT)   dec.op = OP_UEXT;
        else if (instr[31:12] == OPC_BCAST)  dec.op = OP_BCAST;

        if (dec.op == OP_BCAST) begin
            dec.sz = esize_e'(instr[11:10]);
        end else if (dec.op != OP_NONE) begin
            casez (instr[14:10])
                5'b0????: begin dec.sz = SZ_B; dec.idx = instr[13:10];         end
                5'b10???: begin dec.sz = SZ_H; dec.idx = {1'b0, instr[12:10]}; end
                5'b110??: begin dec.sz = SZ_W; dec.idx = {2'b0, instr[11:10]}; end
                5'b1110?: begin dec.sz = SZ_D; dec.idx = {3'b0, instr[10]};    end
                default:  dec.bad = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/vgx_insert.sv
module vgx_insert
    import vgx_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int VLEN = 128
) (
    input  logic [VLEN-1:0] vec_old,
    input  logic [XLEN-1:0] gpr,
    input  esize_e          sz,
    input  logic [3:0]      idx,
    output logic [VLEN-1:0] vec_new
);
    logic [VLEN-1:0] cand [4];

    for (genvar s = 0; s < 4; s++) begin : g_sz
        localparam int W     = 8 << s;
        localparam int LANES = VLEN / W;
        logic [VLEN-1:0] merged;
        always_comb begin
            merged = vec_old;
            for (int l = 0; l < LANES; l++) begin
                if (idx == 4'(l)) merged[l*W +: W] = gpr[W-1:0];
            end
        end
        assign cand[s] = merged;
    end

    assign vec_new = cand[sz];
endmodule

// File: rtl/vgx_extract.sv
module vgx_extract
    import vgx_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int VLEN = 128
) (
    input  logic [VLEN-1:0] vec,
    input  esize_e          sz,
    input  logic [3:0]      idx,
    input  logic            sign_ext,
    output logic [XLEN-1:0] value
);
    logic [XLEN-1:0] cand [4];

    for (genvar s = 0; s < 4; s++) begin : g_sz
        localparam int W     = 8 << s;
        localparam int LANES = VLEN / W;
        logic [W-1:0] lane;
        always_comb begin
            lane = '0;
            for (int l = 0; l < LANES; l++) begin
                if (idx == 4'(l)) lane = vec[l*W +: W];
            end
        end
        if (W < XLEN) begin : g_ext
            assign cand[s] = {{(XLEN-W){sign_ext & lane[W-1]}}, lane};
        end else begin : g_full
            assign cand[s] = lane[XLEN-1:0];
        end
    end

    assign value = cand[sz];
endmodule

// File: rtl/vgx_broadcast.sv
module vgx_broadcast
    import vgx_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int VLEN = 128
) (
    input  logic [XLEN-1:0] gpr,
    input  esize_e          sz,
    output logic [VLEN-1:0] vec
);
    logic [VLEN-1:0] cand [4];

    for (genvar s = 0; s < 4; s++) begin : g_sz
        localparam int W     = 8 << s;
        localparam int LANES = VLEN / W;
        assign cand[s] = {LANES{gpr[W-1:0]}};
    end

    assign vec = cand[sz];
endmodule

// File: rtl/vgx_xfer.sv
module vgx_xfer
    import vgx_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int VLEN = 128,
    parameter int RIDX = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic            ext_en,
    input  logic [XLEN-1:0] gpr_rdata,
    input  logic [VLEN-1:0] vreg_rdata,
    output logic            gpr_we,
    output logic [RIDX-1:0] gpr_waddr,
    output logic [XLEN-1:0] gpr_wdata,
    output logic            vreg_we,
    output logic [RIDX-1:0] vreg_waddr,
    output logic [VLEN-1:0] vreg_wdata,
    output logic            illegal,
    output logic            ext_disabled
);
    typedef struct packed {
        logic            gpr_we;
        logic [RIDX-1:0] gpr_waddr;
        logic [XLEN-1:0] gpr_wdata;
        logic            vreg_we;
        logic [RIDX-1:0] vreg_waddr;
        logic [VLEN-1:0] vreg_wdata;
        logic            illegal;
        logic            ext_dis;
    } out_t;

    xdec_t           dec;
    logic [VLEN-1:0] ins_vec;
    logic [VLEN-1:0] bc_vec;
    logic [XLEN-1:0] ext_val;
    out_t            out_d, out_q;

    vgx_decode u_dec (.instr(instr), .dec(dec));

    vgx_insert #(.XLEN(XLEN), .VLEN(VLEN)) u_ins (
        .vec_old(vreg_rdata), .gpr(gpr_rdata), .sz(dec.sz), .idx(dec.idx), .vec_new(ins_vec)
    );

    vgx_extract #(.XLEN(XLEN), .VLEN(VLEN)) u_ext (
        .vec(vreg_rdata), .sz(dec.sz), .idx(dec.idx),
        .sign_ext(dec.op == OP_SEXT), .value(ext_val)
    );

    vgx_broadcast #(.XLEN(XLEN), .VLEN(VLEN)) u_bc (
        .gpr(gpr_rdata), .sz(dec.sz), .vec(bc_vec)
    );

    always_comb begin
        out_d = '0;
        if (in_valid && dec.op != OP_NONE) begin
            if (!ext_en) begin
                out_d.ext_dis = 1'b1;
            end else if (dec.bad) begin
                out_d.illegal = 1'b1;
            end else begin
                case (dec.op)
                    OP_INSERT: begin
                        out_d.vreg_we    = 1'b1;
                        out_d.vreg_waddr = dec.dst[RIDX-1:0];
                        out_d.vreg_wdata = ins_vec;
                    end
                    OP_BCAST: begin
                        out_d.vreg_we    = 1'b1;
                        out_d.vreg_waddr = dec.dst[RIDX-1:0];
                        out_d.vreg_wdata = bc_vec;
                    end
                    OP_SEXT, OP_UEXT: begin
                        out_d.gpr_we    = 1'b1;
                        out_d.gpr_waddr = dec.dst[RIDX-1:0];
                        out_d.gpr_wdata = ext_val;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign gpr_we       = out_q.gpr_we;
    assign gpr_waddr    = out_q.gpr_waddr;
    assign gpr_wdata    = out_q.gpr_wdata;
    assign vreg_we      = out_q.vreg_we;
    assign vreg_waddr   = out_q.vreg_waddr;
    assign vreg_wdata   = out_q.vreg_wdata;
    assign illegal      = out_q.illegal;
    assign ext_disabled = out_q.ext_dis;
endmodule

// File: rtl/vgx_xfer_chk.sv
module vgx_xfer_chk
    import vgx_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [31:0]  instr,
    input logic         ext_en,
    input logic [63:0]  gpr_rdata,
    input logic         gpr_we,
    input logic [4:0]   gpr_waddr,
    input logic [63:0]  gpr_wdata,
    input logic         vreg_we,
    input logic [4:0]   vreg_waddr,
    input logic [127:0] vreg_wdata,
    input logic         illegal,
    input logic         ext_disabled
);
    a_r2_insert_writes_vreg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ext_en && instr[31:15] == OPC_INSERT && instr[14:11] != 4'b1111)
        |=> (vreg_we && !gpr_we && vreg_waddr == $past(instr[4:0])));

    a_r4_sext_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ext_en && instr[31:15] == OPC_SEXT && !instr[14])
        |=> (gpr_we && (gpr_wdata[63:7] == '0 || gpr_wdata[63:7] == '1)));

    a_r5_uext_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ext_en && instr[31:15] == OPC_UEXT && !instr[14])
        |=> (gpr_we && gpr_wdata[63:8] == '0));

    a_r6_bcast_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ext_en && instr[31:10] == {OPC_BCAST, 2'b00})
        |=> (vreg_we && vreg_wdata == {16{$past(gpr_rdata[7:0])}}));

    a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!gpr_we && !vreg_we && !ext_disabled));

    a_r9_disabled_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ext_disabled |-> (!gpr_we && !vreg_we && !illegal));

    a_r7_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(gpr_we && vreg_we));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!gpr_we && !vreg_we && !illegal && !ext_disabled));
endmodule

bind vgx_xfer vgx_xfer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .ext_en(ext_en),
    .gpr_rdata(gpr_rdata), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
    .vreg_we(vreg_we), .vreg_waddr(vreg_waddr), .vreg_wdata(vreg_wdata),
    .illegal(illegal), .ext_disabled(ext_disabled)
);

// File: tb/vgx_xfer_tb.sv
module vgx_xfer_tb;
    localparam logic [16:0] T_INS  = 17'b0111_00101110_10111;
    localparam logic [16:0] T_SEXT = 17'b0111_00101110_11111;
    localparam logic [16:0] T_UEXT = 17'b0111_00101111_00111;
    localparam logic [19:0] T_BC   = 20'b0111_00101001_11110_000;
    localparam logic [127:0] V1 = 128'h0f0e0d0c0b0a0908_0706050403020100;
    localparam logic [127:0] V2 = 128'hF0E1D2C3B4A59687_78695A4B3C2D1E0F;
    localparam logic [63:0]  G1 = 64'h1122334455667788;

    typedef struct packed {
        logic [31:0]  ins;
        logic         en;
        logic [63:0]  g;
        logic [127:0] v;
        logic         gwe;
        logic         vwe;
        logic [63:0]  gd;
        logic [127:0] vd;
        logic         ill;
        logic         dis;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t TBL [NV] = '{
        // R2 byte lane 5, halfword lane 7, byte lane 0
        '{{T_INS, 5'b00101, 5'd3, 5'd7}, 1'b1, G1, V1, 1'b0, 1'b1, '0, 128'h0f0e0d0c0b0a0908_0706880403020100, 1'b0, 1'b0, 4'd2},
        '{{T_INS, 5'b10111, 5'd3, 5'd9}, 1'b1, G1, V1, 1'b0, 1'b1, '0, 128'h77880d0c0b0a0908_0706050403020100, 1'b0, 1'b0, 4'd2},
        '{{T_INS, 5'b00000, 5'd3, 5'd1}, 1'b1, G1, V1, 1'b0, 1'b1, '0, 128'h0f0e0d0c0b0a0908_0706050403020188, 1'b0, 1'b0, 4'd2},
        // R3 word lane 1, doubleword lane 1
        '{{T_INS, 5'b11001, 5'd3, 5'd30}, 1'b1, G1, V1, 1'b0, 1'b1, '0, 128'h0f0e0d0c0b0a0908_5566778803020100, 1'b0, 1'b0, 4'd3},
        '{{T_INS, 5'b11101, 5'd3, 5'd31}, 1'b1, G1, V1, 1'b0, 1'b1, '0, 128'h1122334455667788_0706050403020100, 1'b0, 1'b0, 4'd3},
        // R4 / R5 extracts
        '{{T_SEXT, 5'b01111, 5'd4, 5'd1}, 1'b1, G1, V2, 1'b1, 1'b0, 64'hFFFFFFFFFFFFFFF0, '0, 1'b0, 1'b0, 4'd4},
        '{{T_UEXT, 5'b01111, 5'd4, 5'd2}, 1'b1, G1, V2, 1'b1, 1'b0, 64'h00000000000000F0, '0, 1'b0, 1'b0, 4'd5},
        '{{T_SEXT, 5'b00010, 5'd4, 5'd3}, 1'b1, G1, V2, 1'b1, 1'b0, 64'h000000000000002D, '0, 1'b0, 1'b0, 4'd4},
        '{{T_SEXT, 5'b10100, 5'd4, 5'd4}, 1'b1, G1, V2, 1'b1, 1'b0, 64'hFFFFFFFFFFFF9687, '0, 1'b0, 1'b0, 4'd4},
        '{{T_UEXT, 5'b10100, 5'd4, 5'd5}, 1'b1, G1, V2, 1'b1, 1'b0, 64'h0000000000009687, '0, 1'b0, 1'b0, 4'd5},
        '{{T_SEXT, 5'b11010, 5'd4, 5'd6}, 1'b1, G1, V2, 1'b1, 1'b0, 64'hFFFFFFFFB4A59687, '0, 1'b0, 1'b0, 4'd4},
        '{{T_UEXT, 5'b11010, 5'd4, 5'd7}, 1'b1, G1, V2, 1'b1, 1'b0, 64'h00000000B4A59687, '0, 1'b0, 1'b0, 4'd5},
        '{{T_SEXT, 5'b11000, 5'd4, 5'd8}, 1'b1, G1, V2, 1'b1, 1'b0, 64'h000000003C2D1E0F, '0, 1'b0, 1'b0, 4'd4},
        '{{T_SEXT, 5'b11101, 5'd4, 5'd9}, 1'b1, G1, V2, 1'b1, 1'b0, 64'hF0E1D2C3B4A59687, '0, 1'b0, 1'b0, 4'd5},
        '{{T_UEXT, 5'b11101, 5'd4, 5'd10}, 1'b1, G1, V2, 1'b1, 1'b0, 64'hF0E1D2C3B4A59687, '0, 1'b0, 1'b0, 4'd5},
        // R6 broadcast, all size codes
        '{{T_BC, 2'b00, 5'd2, 5'd6}, 1'b1, G1, V2, 1'b0, 1'b1, '0, {16{8'h88}}, 1'b0, 1'b0, 4'd6},
        '{{T_BC, 2'b01, 5'd2, 5'd11}, 1'b1, G1, V2, 1'b0, 1'b1, '0, {8{16'h7788}}, 1'b0, 1'b0, 4'd6},
        '{{T_BC, 2'b10, 5'd2, 5'd12}, 1'b1, G1, V2, 1'b0, 1'b1, '0, {4{32'h55667788}}, 1'b0, 1'b0, 4'd6},
        '{{T_BC, 2'b11, 5'd2, 5'd13}, 1'b1, G1, V2, 1'b0, 1'b1, '0, {2{G1}}, 1'b0, 1'b0, 4'd6},
        // R8 malformed prefix
        '{{T_INS, 5'b11110, 5'd3, 5'd7}, 1'b1, G1, V1, 1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 4'd8},
        '{{T_UEXT, 5'b11111, 5'd3, 5'd7}, 1'b1, G1, V1, 1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 4'd8},
        // R9 extension disabled
        '{{T_INS, 5'b00101, 5'd3, 5'd7}, 1'b0, G1, V1, 1'b0, 1'b0, '0, '0, 1'b0, 1'b1, 4'd9},
        '{{T_BC, 2'b11, 5'd2, 5'd6}, 1'b0, G1, V1, 1'b0, 1'b0, '0, '0, 1'b0, 1'b1, 4'd9},
        '{{T_SEXT, 5'b11111, 5'd3, 5'd7}, 1'b0, G1, V1, 1'b0, 1'b0, '0, '0, 1'b0, 1'b1, 4'd9},
        // R10 foreign words
        '{32'h0000_0000, 1'b1, G1, V1, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 4'd10}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic         ext_en = 1'b1;
    logic [63:0]  gpr_rdata = '0;
    logic [127:0] vreg_rdata = '0;
    logic         gpr_we, vreg_we, illegal, ext_disabled;
    logic [4:0]   gpr_waddr, vreg_waddr;
    logic [63:0]  gpr_wdata;
    logic [127:0] vreg_wdata;
    int           n_chk = 0;
    int           n_err = 0;

    always #10 clk = ~clk;

    vgx_xfer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .ext_en(ext_en),
        .gpr_rdata(gpr_rdata), .vreg_rdata(vreg_rdata),
        .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
        .vreg_we(vreg_we), .vreg_waddr(vreg_waddr), .vreg_wdata(vreg_wdata),
        .illegal(illegal), .ext_disabled(ext_disabled)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_quiet(input string req);
        chk(req, 128'({gpr_we, vreg_we, illegal, ext_disabled}), 128'd0);
    endtask

    initial begin
        #3_000_000;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1: valid insert held during reset must not leak out
        in_valid   = 1'b1;
        instr      = {T_INS, 5'b00101, 5'd3, 5'd7};
        gpr_rdata  = G1;
        vreg_rdata = V1;
        repeat (3) @(negedge clk);
        chk_quiet("R1 during reset");
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
        chk_quiet("R1 after reset");

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag        = $sformatf("R%0d vec%0d", TBL[i].req, i);
            in_valid   = 1'b1;
            instr      = TBL[i].ins;
            ext_en     = TBL[i].en;
            gpr_rdata  = TBL[i].g;
            vreg_rdata = TBL[i].v;
            @(negedge clk);
            chk({tag, " flags"}, 128'({gpr_we, vreg_we, illegal, ext_disabled}),
                128'({TBL[i].gwe, TBL[i].vwe, TBL[i].ill, TBL[i].dis}));
            if (TBL[i].gwe) begin
                chk({tag, " gpr_wdata"}, 128'(gpr_wdata), 128'(TBL[i].gd));
                chk({tag, " R7 gpr_waddr"}, 128'(gpr_waddr), 128'(TBL[i].ins[4:0]));
            end
            if (TBL[i].vwe) begin
                chk({tag, " vreg_wdata"}, vreg_wdata, TBL[i].vd);
                chk({tag, " R7 vreg_waddr"}, 128'(vreg_waddr), 128'(TBL[i].ins[4:0]));
            end
        end

        // R10: broadcast near miss (bit 12 set)
        instr  = {20'b0111_00101001_11110_001, 2'b00, 5'd2, 5'd6};
        ext_en = 1'b1;
        @(negedge clk);
        chk_quiet("R10 near-miss broadcast");

        // R11: valid-looking insert with in_valid low
        in_valid = 1'b0;
        instr    = {T_INS, 5'b00000, 5'd3, 5'd7};
        @(negedge clk);
        chk_quiet("R11 no valid");

        // R11: one-cycle latency, nothing visible before the edge
        in_valid = 1'b1;
        instr    = {T_BC, 2'b00, 5'd2, 5'd6};
        #1;
        chk("R11 before edge", 128'(vreg_we), 128'd0);
        @(negedge clk);
        chk("R11 after edge", 128'(vreg_we), 128'd1);
        in_valid = 1'b0;
        @(negedge clk);
        chk_quiet("R11 drop valid");

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule